// File: doc/BRIEF.md
# Flash Code Prefetch Controller

This block sits between the 32-bit instruction-fetch port of a processor and a wide embedded flash array, and its job is to keep a sequential code stream running without stalls. The flash is read one aligned line at a time. A line is 16 bytes by default, and a runtime mode bit shortens it to 8 bytes when lower power matters more than throughput. Each array read takes a programmable number of wait states plus one cycle. A setting of zero therefore gives single-cycle array access.

Two line buffers hold flash lines. When a fetch hits one buffer, the controller reads the next sequential line into the other buffer. That buffer is freed at the moment the read is issued. As the processor walks forward, the two buffers take turns serving the current line and holding the next one.

A fetch that hits neither buffer is a branch or a cold start. It cancels any read in flight, loads its own line into buffer 0 and holds the ready signal low until that line arrives. A fetch whose line is already being read simply waits for that read. Idle cycles leave the buffers untouched. Byte, halfword and word fetches are served from a buffer hit, and the result is zero-extended to 32 bits. Only the low address bits that span the flash are decoded, so the contents repeat across the whole address window.

The processor holds `fetch_valid`, `fetch_addr` and `fetch_size` steady until it sees `fetch_ready` high. In that same cycle `fetch_rdata` carries the result.

Top module: `pfc_code_prefetch`

## Requirements
- R1: An array read issued in one cycle delivers its line `cfg_wait_states`+1 cycles later. A fetch that misses while the array is idle sees `fetch_ready` low for exactly `cfg_wait_states`+2 cycles, counting from its first cycle.
- R2: With `cfg_narrow`=0 a line is 16 aligned bytes, and the word within it is chosen by `fetch_addr[3:2]`. With `cfg_narrow`=1 a line is 8 aligned bytes, and the word is chosen by `fetch_addr[2]`.
- R3: A hit in one buffer starts a read of the following line into the other buffer, and that buffer is invalidated at issue. No read starts if the other buffer already holds that line or the array is already reading it. The buffers therefore alternate along a sequential stream.
- R4: In 16-byte mode with at most 2 wait states, back-to-back sequential word fetches after the first line never see `fetch_ready` low.
- R5: Cycles with `fetch_valid` low neither discard a valid buffer nor cancel a read in flight.
- R6: `fetch_size` encodes 0 as byte, 1 as halfword, and 2 or 3 as word. A byte is taken from lane `fetch_addr[1:0]` and a halfword from half `fetch_addr[1]`. Both are zero-extended into `fetch_rdata`.
- R7: Only `fetch_addr[FLASH_AW-1:0]` selects data. Addresses that differ only in higher bits return the same data and hit the same buffer.
- R8: A fetch that hits no buffer and does not match the line in flight aborts that read and starts a read of its own line into buffer 0. A fetch that matches the line in flight waits for it without restarting it.
- R9: A change of `cfg_wait_states` or `cfg_narrow` holds `fetch_ready` low for that cycle, invalidates both buffers and aborts any read in flight.
- R10: `fetch_ready` is never high without `fetch_valid`. After reset both buffers are empty and `fetch_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wait_states | input | WS_W | Extra cycles per array read |
| cfg_narrow | input | 1 | 1 selects 8-byte lines, 0 selects 16-byte lines |
| fetch_valid | input | 1 | Code fetch request, held until ready |
| fetch_addr | input | ADDR_W | Byte address of the fetch |
| fetch_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| fetch_ready | output | 1 | Request served this cycle |
| fetch_rdata | output | 32 | Zero-extended read data, valid with ready |

## Verification
The bench builds the block with a 1 KiB flash (`FLASH_AW`=10), a 16-bit address window and a 3-bit wait-state field. With these values, addresses 1024 bytes apart alias within a short run, and wait settings of 0 to 3 can be swept in both line widths. Those settings show where a prefetch arrives in time and where it leaves a one-cycle stall. A behavioural model of the buffers and the array timing predicts `fetch_ready` on every cycle. The expected data is computed directly from the address, without reference to any buffer.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } fetch_size_e;

  localparam int LINE_BITS = 128;

  // Content of flash word number widx (array model pattern)
  function automatic logic [31:0] flash_word(input logic [15:0] widx);
    return {widx ^ 16'hA5C3, widx ^ 16'h96E1};
  endfunction

  // Select word, then lane, from a buffered line; zero-extend
  function automatic logic [31:0] pick_lane(input logic [LINE_BITS-1:0] line,
                                            input logic [3:0] lo,
                                            input logic narrow,
                                            input fetch_size_e sz);
    logic [1:0]  ws;
    logic [31:0] w;
    ws = narrow ? {1'b0, lo[2]} : lo[3:2];
    w  = line[ws*32 +: 32];
    case (sz)
      SZ_BYTE: return {24'd0, w[lo[1:0]*8 +: 8]};
      SZ_HALF: return {16'd0, w[lo[1]*16 +: 16]};
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/pfc_flash_array.sv
module pfc_flash_array import pfc_pkg::*; #(
  parameter int FLASH_AW = 12,
  parameter int WS_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [FLASH_AW-4:0]   start_line_i,
  input  logic                  narrow_i,
  input  logic [WS_W-1:0]       wait_i,
  input  logic                  abort_i,
  output logic                  busy_o,
  output logic [FLASH_AW-4:0]   line_o,
  output logic                  done_o,
  output logic [LINE_BITS-1:0]  rdata_o
);
  localparam int LINE_W = FLASH_AW - 3;

  logic              busy_q, nar_q;
  logic [WS_W-1:0]   cnt_q;
  logic [LINE_W-1:0] line_q;

  assign busy_o = busy_q;
  assign line_o = line_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      nar_q  <= 1'b0;
      cnt_q  <= '0;
      line_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      nar_q  <= narrow_i;
      cnt_q  <= wait_i;
      line_q <= start_line_i;
    end else if (abort_i || done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Line contents, computed from the latched line number
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      logic [15:0] widx;
      if (nar_q) widx = 16'({line_q, 1'b0}) + 16'(i);
      else       widx = 16'({line_q[LINE_W-2:0], 2'b00}) + 16'(i);
      if (nar_q && i >= 2) rdata_o[i*32 +: 32] = '0;
      else                 rdata_o[i*32 +: 32] = flash_word(widx);
    end
  end

  a_r1_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

  a_r1_zero_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && wait_i == '0) |=> done_o);

endmodule

// File: rtl/pfc_line_store.sv
module pfc_line_store import pfc_pkg::*; #(
  parameter int LINE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_all_i,
  input  logic                  clr_en_i,
  input  logic                  clr_idx_i,
  input  logic                  wr_en_i,
  input  logic                  wr_idx_i,
  input  logic [LINE_W-1:0]     wr_tag_i,
  input  logic [LINE_BITS-1:0]  wr_data_i,
  input  logic [LINE_W-1:0]     look_tag_i,
  input  logic [LINE_W-1:0]     next_tag_i,
  output logic                  hit_o,
  output logic                  hit_idx_o,
  output logic [LINE_BITS-1:0]  hit_line_o,
  output logic                  other_has_next_o,
  output logic [1:0]            valid_o
);
  localparam int N_BUF = 2;

  logic [N_BUF-1:0]                vld;
  logic [N_BUF-1:0][LINE_W-1:0]    tag_w;
  logic [N_BUF-1:0][LINE_BITS-1:0] dat_w;
  logic [N_BUF-1:0]                hit_vec;

  for (genvar g = 0; g < N_BUF; g++) begin : gen_ent
    logic                 valid_q;
    logic [LINE_W-1:0]    tag_q;
    logic [LINE_BITS-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        tag_q   <= '0;
        data_q  <= '0;
      end else if (clr_all_i) begin
        valid_q <= 1'b0;
      end else if (wr_en_i && wr_idx_i == 1'(g)) begin
        valid_q <= 1'b1;
        tag_q   <= wr_tag_i;
        data_q  <= wr_data_i;
      end else if (clr_en_i && clr_idx_i == 1'(g)) begin
        valid_q <= 1'b0;
      end
    end

    assign vld[g]     = valid_q;
    assign tag_w[g]   = tag_q;
    assign dat_w[g]   = data_q;
    assign hit_vec[g] = valid_q && (tag_q == look_tag_i);
  end

  assign hit_o            = |hit_vec;
  assign hit_idx_o        = hit_vec[1];
  assign hit_line_o       = dat_w[hit_idx_o];
  assign other_has_next_o = vld[~hit_idx_o] && (tag_w[~hit_idx_o] == next_tag_i);
  assign valid_o          = vld;

  // R3: a line never sits valid in both buffers
  a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/pfc_lane_pick.sv
module pfc_lane_pick import pfc_pkg::*; (
  input  logic [LINE_BITS-1:0] line_i,
  input  logic [3:0]           lo_i,
  input  logic                 narrow_i,
  input  logic [1:0]           size_i,
  output logic [31:0]          data_o
);
  assign data_o = pick_lane(line_i, lo_i, narrow_i, fetch_size_e'(size_i));
endmodule

// File: rtl/pfc_code_prefetch.sv
module pfc_code_prefetch import pfc_pkg::*; #(
  parameter int ADDR_W   = 20,
  parameter int FLASH_AW = 12,
  parameter int WS_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WS_W-1:0]   cfg_wait_states,
  input  logic              cfg_narrow,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [1:0]        fetch_size,
  output logic              fetch_ready,
  output logic [31:0]       fetch_rdata
);
  localparam int LINE_W = FLASH_AW - 3;
  localparam logic [LINE_W-1:0] ONE_L = 1;
  localparam logic [LINE_W-2:0] ONE_S = 1;

  function automatic logic [LINE_W-1:0] line_of(input logic [FLASH_AW-1:0] off,
                                                input logic nar);
    return nar ? off[FLASH_AW-1:3] : {1'b0, off[FLASH_AW-1:4]};
  endfunction

  function automatic logic [LINE_W-1:0] next_line(input logic [LINE_W-1:0] l,
                                                  input logic nar);
    return nar ? (l + ONE_L) : {1'b0, l[LINE_W-2:0] + ONE_S};
  endfunction

  // Bits above the flash span only alias (R7)
  logic addr_unused;
  assign addr_unused = ^fetch_addr[ADDR_W-1:FLASH_AW];

  // Configuration tracking (R9)
  logic [WS_W-1:0] wait_q;
  logic            narrow_q;
  logic            cfg_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q   <= '0;
      narrow_q <= 1'b0;
    end else begin
      wait_q   <= cfg_wait_states;
      narrow_q <= cfg_narrow;
    end
  end
  assign cfg_chg = (cfg_wait_states != wait_q) || (cfg_narrow != narrow_q);

  // Named internal events
  logic [LINE_W-1:0]    req_line, nxt_line, start_line, fl_line;
  logic                 hit, hit_idx, other_has_next;
  logic                 inflight_req, inflight_next;
  logic                 pf_start, dm_start, fl_start, start_buf;
  logic                 fl_busy, fl_done, buf_wr;
  logic [1:0]           buf_valid;
  logic [LINE_BITS-1:0] fl_rdata, hit_line;
  logic                 op_buf_q;

  assign req_line      = line_of(fetch_addr[FLASH_AW-1:0], cfg_narrow);
  assign nxt_line      = next_line(req_line, cfg_narrow);
  assign inflight_req  = fl_busy && (fl_line == req_line);
  assign inflight_next = fl_busy && (fl_line == nxt_line);

  assign pf_start   = fetch_valid && !cfg_chg && hit && !other_has_next && !inflight_next;
  assign dm_start   = fetch_valid && !cfg_chg && !hit && !inflight_req;
  assign fl_start   = pf_start || dm_start;
  assign start_line = dm_start ? req_line : nxt_line;
  assign start_buf  = dm_start ? 1'b0 : ~hit_idx;
  assign buf_wr     = fl_done && !fl_start && !cfg_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        op_buf_q <= 1'b0;
    else if (fl_start) op_buf_q <= start_buf;
  end

  pfc_flash_array #(.FLASH_AW(FLASH_AW), .WS_W(WS_W)) u_array (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (fl_start),
    .start_line_i (start_line),
    .narrow_i     (cfg_narrow),
    .wait_i       (cfg_wait_states),
    .abort_i      (cfg_chg),
    .busy_o       (fl_busy),
    .line_o       (fl_line),
    .done_o       (fl_done),
    .rdata_o      (fl_rdata)
  );

  pfc_line_store #(.LINE_W(LINE_W)) u_store (
    .clk              (clk),
    .rst_n            (rst_n),
    .clr_all_i        (cfg_chg),
    .clr_en_i         (fl_start),
    .clr_idx_i        (start_buf),
    .wr_en_i          (buf_wr),
    .wr_idx_i         (op_buf_q),
    .wr_tag_i         (fl_line),
    .wr_data_i        (fl_rdata),
    .look_tag_i       (req_line),
    .next_tag_i       (nxt_line),
    .hit_o            (hit),
    .hit_idx_o        (hit_idx),
    .hit_line_o       (hit_line),
    .other_has_next_o (other_has_next),
    .valid_o          (buf_valid)
  );

  pfc_lane_pick u_lane (
    .line_i   (hit_line),
    .lo_i     (fetch_addr[3:0]),
    .narrow_i (cfg_narrow),
    .size_i   (fetch_size),
    .data_o   (fetch_rdata)
  );

  assign fetch_ready = fetch_valid && hit && !cfg_chg;

  a_r9_cfg_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (buf_valid == 2'b00));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !cfg_chg && !fl_done) |=> (buf_valid == $past(buf_valid)));

  a_r3_freed_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> !buf_valid[op_buf_q]);

  a_r6_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ready && fetch_size == 2'd0) |-> (fetch_rdata[31:8] == 24'd0));

endmodule

// File: tb/sim_pfc_code_prefetch.sv
`timescale 1ns/1ps
module sim_pfc_code_prefetch;
  localparam int ADDR_W = 16, FLASH_AW = 10, WS_W = 3;
  localparam int FBYTES = 1 << FLASH_AW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [WS_W-1:0]   cfg_wait = '0;
  logic              cfg_nar = 1'b0;
  logic              fv = 1'b0;
  logic [ADDR_W-1:0] fa = '0;
  logic [1:0]        fs = 2'd2;
  logic              ready;
  logic [31:0]       rdata;

  always #4 clk = ~clk;

  pfc_code_prefetch #(.ADDR_W(ADDR_W), .FLASH_AW(FLASH_AW), .WS_W(WS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wait_states(cfg_wait), .cfg_narrow(cfg_nar),
    .fetch_valid(fv), .fetch_addr(fa), .fetch_size(fs),
    .fetch_ready(ready), .fetch_rdata(rdata));

  int n_checks = 0, n_fail = 0;
  logic [31:0] lastd;

  // Behavioural model state
  bit mv[2];
  int mt[2];
  bit mbusy = 0;
  int mline = 0, mcnt = 0, mbuf = 0, qwait = 0;
  bit qnar = 0;

  function automatic logic [31:0] fword(int w);
    logic [15:0] x;
    x = w[15:0];
    return {x ^ 16'hA5C3, x ^ 16'h96E1};
  endfunction

  function automatic logic [31:0] exp_data(int a, int sz);
    logic [31:0] v;
    v = fword((a % FBYTES) / 4);
    if (sz == 0) return (v >> (8 * (a % 4))) & 32'hFF;
    if (sz == 1) return (v >> (16 * ((a / 2) % 2))) & 32'hFFFF;
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: sample before the rising edge, compare, advance model
  task automatic step(output bit got);
    int lsz, nl, L, N, hb, sl, sb;
    bit chg, done, st, expr;
    #3;
    lsz = cfg_nar ? 8 : 16;
    nl  = FBYTES / lsz;
    L   = (int'(fa) % FBYTES) / lsz;
    N   = (L + 1) % nl;
    chg = (int'(cfg_wait) != qwait) || (cfg_nar != qnar);
    hb  = -1;
    for (int b = 0; b < 2; b++) if (mv[b] && mt[b] == L) hb = b;
    expr = fv && (hb >= 0) && !chg;
    check(ready == expr, "R10 ready timing", {31'd0, ready}, {31'd0, expr});
    if (ready && expr)
      check(rdata == exp_data(int'(fa), int'(fs)), "R6 read data", rdata,
            exp_data(int'(fa), int'(fs)));
    got = ready;
    if (ready) lastd = rdata;
    done = mbusy && mcnt == 0;
    st = 0; sl = 0; sb = 0;
    if (fv && !chg) begin
      if (hb >= 0) begin
        if (!(mv[1-hb] && mt[1-hb] == N) && !(mbusy && mline == N)) begin
          st = 1; sl = N; sb = 1 - hb;
        end
      end else if (!(mbusy && mline == L)) begin
        st = 1; sl = L; sb = 0;
      end
    end
    if (chg) begin
      mv[0] = 0; mv[1] = 0;
    end else begin
      if (done && !st) begin mv[mbuf] = 1; mt[mbuf] = mline; end
      if (st) mv[sb] = 0;
    end
    if (st) begin
      mbusy = 1; mcnt = int'(cfg_wait); mline = sl; mbuf = sb;
    end else if (chg || done) mbusy = 0;
    else if (mbusy) mcnt--;
    qwait = int'(cfg_wait);
    qnar  = cfg_nar;
    @(negedge clk);
  endtask

  task automatic fetch(int a, int sz, int gap, output int stalls);
    bit g;
    fv = 1'b0;
    repeat (gap) step(g);
    fv = 1'b1; fa = a[ADDR_W-1:0]; fs = sz[1:0];
    stalls = 0;
    forever begin
      step(g);
      if (g) break;
      stalls++;
      if (stalls > 100) begin
        check(0, "R1 request never served", 32'(stalls), 32'd0);
        break;
      end
    end
    fv = 1'b0;
  endtask

  task automatic expect_stall(int a, int sz, int gap, int exp, string tag);
    int s;
    fetch(a, sz, gap, s);
    check(s == exp, tag, 32'(s), 32'(exp));
  endtask

  initial begin
    #(8 * 200000);
    check(0, "R10 watchdog expired", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int s, tot;
    bit g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(g);
    check(ready == 1'b0, "R10 reset leaves ready low", {31'd0, ready}, 32'd0);

    // Wait 0, wide lines
    expect_stall(0, 2, 1, 2, "R1 miss latency wait=0");
    expect_stall(4, 2, 0, 0, "R2 same 16-byte line hits");
    expect_stall(12, 2, 0, 0, "R2 word 3 of wide line");
    tot = 0;
    for (int a = 16; a < 96; a += 4) begin fetch(a, 2, 0, s); tot += s; end
    check(tot == 0, "R4 sequential stream wait=0", 32'(tot), 32'd0);

    // Wait 2: flush, then stall-free alternation
    cfg_wait = 3'd2;
    expect_stall(128, 2, 1, 4, "R1 miss latency wait=2");
    tot = 0;
    for (int a = 132; a < 256; a += 4) begin fetch(a, 2, 0, s); tot += s; end
    check(tot == 0, "R3 R4 alternating prefetch keeps stream stall-free", 32'(tot), 32'd0);

    // Wait 3: idle gaps
    cfg_wait = 3'd3;
    expect_stall(320, 2, 1, 5, "R1 miss latency wait=3");
    expect_stall(336, 2, 6, 0, "R5 prefetch survives idle gap");
    expect_stall(340, 2, 10, 0, "R5 buffer survives idle gap");

    // Narrow lines, wait 1
    cfg_nar = 1'b1; cfg_wait = 3'd1;
    expect_stall(0, 2, 1, 3, "R9 flush on mode change");
    expect_stall(4, 2, 0, 0, "R2 narrow line hit");
    expect_stall(8, 2, 0, 1, "R2 narrow line is 8 bytes");

    // Wide lines, wait 1
    cfg_nar = 1'b0;
    expect_stall(0, 2, 1, 3, "R9 flush on width change back");
    expect_stall(8, 2, 0, 0, "R2 wide line holds byte 8");
    expect_stall(12, 2, 0, 0, "R2 wide line holds byte 12");

    // Branches
    expect_stall(512, 2, 1, 3, "R8 branch miss");
    expect_stall(704, 2, 0, 3, "R8 branch aborts prefetch");
    expect_stall(528, 2, 0, 3, "R8 discarded line fetched again");

    // Aliasing and sub-word lanes
    expect_stall(528 + FBYTES, 2, 0, 0, "R7 alias hits buffer");
    check(lastd == exp_data(528, 2), "R7 alias data", lastd, exp_data(528, 2));
    expect_stall(529, 0, 0, 0, "R6 byte hit");
    check(lastd == exp_data(529, 0), "R6 byte lane 1", lastd, exp_data(529, 0));
    expect_stall(531, 0, 0, 0, "R6 byte hit");
    check(lastd == exp_data(531, 0), "R6 byte lane 3", lastd, exp_data(531, 0));
    expect_stall(530, 1, 0, 0, "R6 half hit");
    check(lastd == exp_data(530, 1), "R6 upper half", lastd, exp_data(530, 1));
    expect_stall(532, 1, 0, 0, "R6 half hit");
    check(lastd == exp_data(532, 1), "R6 lower half", lastd, exp_data(532, 1));

    // Wait change flushes; in-flight line waits
    cfg_wait = 3'd3;
    expect_stall(528, 2, 1, 5, "R9 wait change flushes buffers");
    expect_stall(544, 2, 0, 4, "R8 in-flight line waits, not restarted");

    fv = 1'b0;
    step(g);
    check(ready == 1'b0, "R10 no ready without request", {31'd0, ready}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule